// File: doc/BRIEF.md
# Dual-Output Interrupt Source Conditioner

This block gathers 26 interrupt sources and turns them into two active-low processor request lines: a fast request and a normal request. Each source is conditioned on its own. A source mask can block it. A trigger-mode bit selects level or edge sensitivity, and a polarity bit selects which level or which edge counts as active. A routing bit then assigns the source to the fast group or the normal group. Each group has its own status view and its own per-source group mask. A request line goes low when any pending, unmasked status bit exists in its group.

External sources pass through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the sample from the previous cycle. Edge-mode status is latched and software clears it with a write-one-to-clear register. Level-mode status simply tracks the qualified input.

The highest source is a software interrupt taken from a register bit. It is always level sensitive and active high. A test register can replace all source inputs, the software bit included, so that software can drive the conditioning logic directly. A simple synchronous write / combinational read port gives access to the configuration.

Top module: `dic_top`

## Requirements
- R1: After reset, n_fiq_o and n_irq_o are high. The registers read back as follows: source mask (address 0), fast-group mask (4) and normal-group mask (5) are all ones in bits 25:0. Trigger mode (1), routing (3), test (7), both status views (8, 9) and software bit (10) read 0. Polarity (2) reads 0x2000000.
- R2: When a level-mode source's bit in the source mask (address 0) is 1, its status stays 0 whatever the input does. Unmasking it (bit 0) lets status follow the input.
- R3: A source in level mode (trigger bit 0 at address 1) has status 1 while its input equals its polarity bit (address 2: 1 = active high, 0 = active low). Status returns to 0 when the input goes inactive.
- R4: A source in edge mode (trigger bit 1) sets its status on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The status stays set after the input returns to its idle level.
- R5: Writing 1 to a source's bit in the clear register (address 6) clears latched edge-mode status. The same write has no effect on a level-mode source whose input is still active.
- R6: If an edge-mode set and a clear of the same source land in the same cycle, the status ends up set.
- R7: A source whose routing bit (address 3) is 1 shows its status only in the fast-group status view (address 8). A source whose routing bit is 0 shows it only in the normal-group view (address 9).
- R8: n_fiq_o is low exactly when some bit of (fast status AND NOT fast-group mask) was 1 in the previous cycle. n_irq_o behaves the same way for the normal group. Both outputs are registered.
- R9: Test register (address 7) bit 26 enables test mode, and reset clears it. While it is set, bits 25:0 replace all sources, and src_i has no effect on status.
- R10: Source 25 follows the software bit (address 10, bit 0). It is always level sensitive and active high. Its trigger-mode bit reads 0 and its polarity bit reads 1 regardless of what is written.
- R11: A change on src_i shows up in the status view on the third rising clock edge after the change, and in the request output one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 25 | External interrupt sources 24:0 (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 27 | Register write data |
| reg_rdata_o | output | 27 | Register read data (combinational) |
| n_fiq_o | output | 1 | Fast request, active low |
| n_irq_o | output | 1 | Normal request, active low |

## Verification
The main sweep runs through test mode and covers every hardware source under all four combinations of trigger mode and polarity. The routing alternates between groups from one source to the next. In each trial the bench drives an idle, then active, then idle pattern and issues a clear at one point. This separates level tracking from edge latching, rising edges from falling edges, and clears that take effect from clears that are ignored. A second set of directed patterns uses the external pins. These time the synchronizer delay edge by edge, make a set and a clear collide in the same cycle, and confirm that external inputs are ignored in test mode. A last group of patterns drives the software source with mode and polarity written against it.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    RA_SRC_MASK = 4'd0,
    RA_TRIG     = 4'd1,
    RA_POL      = 4'd2,
    RA_ROUTE    = 4'd3,
    RA_FMASK    = 4'd4,
    RA_IMASK    = 4'd5,
    RA_CLEAR    = 4'd6,
    RA_TEST     = 4'd7,
    RA_FSTAT    = 4'd8,
    RA_ISTAT    = 4'd9,
    RA_SWI      = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/dic_sync.sv
module dic_sync #(
  parameter int unsigned W      = 25,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dic_regs.sv
module dic_regs
  import dic_pkg::*;
#(
  parameter  int unsigned N_SRC = 26,
  localparam int unsigned DW    = N_SRC + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_SRC-1:0] fstat_i,
  input  logic [N_SRC-1:0] istat_i,
  output logic [N_SRC-1:0] src_mask_o,
  output logic [N_SRC-1:0] trig_o,
  output logic [N_SRC-1:0] pol_o,
  output logic [N_SRC-1:0] route_o,
  output logic [N_SRC-1:0] fmask_o,
  output logic [N_SRC-1:0] imask_o,
  output logic [N_SRC-1:0] clr_o,
  output logic             test_en_o,
  output logic [N_SRC-1:0] test_val_o,
  output logic             swi_o
);
  localparam int unsigned NH = N_SRC - 1;  // hardware-configurable mode/polarity bits

  logic [N_SRC-1:0] src_mask_q, route_q, fmask_q, imask_q, test_val_q;
  logic [NH-1:0]    trig_q, pol_q;
  logic             test_en_q, swi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_mask_q <= '1;
      trig_q     <= '0;
      pol_q      <= '0;
      route_q    <= '0;
      fmask_q    <= '1;
      imask_q    <= '1;
      test_en_q  <= 1'b0;
      test_val_q <= '0;
      swi_q      <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        RA_SRC_MASK: src_mask_q <= wdata_i[N_SRC-1:0];
        RA_TRIG:     trig_q     <= wdata_i[NH-1:0];
        RA_POL:      pol_q      <= wdata_i[NH-1:0];
        RA_ROUTE:    route_q    <= wdata_i[N_SRC-1:0];
        RA_FMASK:    fmask_q    <= wdata_i[N_SRC-1:0];
        RA_IMASK:    imask_q    <= wdata_i[N_SRC-1:0];
        RA_TEST:     {test_en_q, test_val_q} <= wdata_i;
        RA_SWI:      swi_q      <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // software source: level, active high, fixed
  assign trig_o     = {1'b0, trig_q};
  assign pol_o      = {1'b1, pol_q};
  assign src_mask_o = src_mask_q;
  assign route_o    = route_q;
  assign fmask_o    = fmask_q;
  assign imask_o    = imask_q;
  assign test_en_o  = test_en_q;
  assign test_val_o = test_val_q;
  assign swi_o      = swi_q;
  assign clr_o      = (we_i && addr_i == RA_CLEAR) ? wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_SRC_MASK: rdata_o = {1'b0, src_mask_q};
      RA_TRIG:     rdata_o = {1'b0, trig_o};
      RA_POL:      rdata_o = {1'b0, pol_o};
      RA_ROUTE:    rdata_o = {1'b0, route_q};
      RA_FMASK:    rdata_o = {1'b0, fmask_q};
      RA_IMASK:    rdata_o = {1'b0, imask_q};
      RA_TEST:     rdata_o = {test_en_q, test_val_q};
      RA_FSTAT:    rdata_o = {1'b0, fstat_i};
      RA_ISTAT:    rdata_o = {1'b0, istat_i};
      RA_SWI:      rdata_o = {{(DW-1){1'b0}}, swi_q};
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dic_cond.sv
module dic_cond #(
  parameter int unsigned N_SRC = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] stat_o
);
  logic [N_SRC-1:0] prev_q, stat_q, stat_d;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic act, hit;
    assign act = (raw_i[g] == pol_i[g]);
    assign hit = pol_i[g] ? (raw_i[g] & ~prev_q[g]) : (~raw_i[g] & prev_q[g]);
    // edge: set has priority over clear
    assign stat_d[g] = trig_i[g] ? ((hit & ~mask_i[g]) | (stat_q[g] & ~clr_i[g]))
                                 : (act & ~mask_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= raw_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/dic_top.sv
module dic_top
  import dic_pkg::*;
#(
  parameter  int unsigned N_SRC       = 26,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_EXT       = N_SRC - 1,
  localparam int unsigned DW          = N_SRC + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] src_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             n_fiq_o,
  output logic             n_irq_o
);
  logic [N_EXT-1:0] src_sync;
  logic [N_SRC-1:0] src_mask, trig, pol, route, fiq_mask, irq_mask, clr;
  logic [N_SRC-1:0] test_val, raw, stat, fiq_stat, irq_stat;
  logic             test_en, swi;
  logic             n_fiq_q, n_irq_q;

  dic_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  dic_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .fstat_i   (fiq_stat),
    .istat_i   (irq_stat),
    .src_mask_o(src_mask),
    .trig_o    (trig),
    .pol_o     (pol),
    .route_o   (route),
    .fmask_o   (fiq_mask),
    .imask_o   (irq_mask),
    .clr_o     (clr),
    .test_en_o (test_en),
    .test_val_o(test_val),
    .swi_o     (swi)
  );

  assign raw = test_en ? test_val : {swi, src_sync};

  dic_cond #(.N_SRC(N_SRC)) u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .trig_i(trig),
    .pol_i (pol),
    .mask_i(src_mask),
    .clr_i (clr),
    .stat_o(stat)
  );

  assign fiq_stat = stat & route;
  assign irq_stat = stat & ~route;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_fiq_q <= 1'b1;
      n_irq_q <= 1'b1;
    end else begin
      n_fiq_q <= ~|(fiq_stat & ~fiq_mask);
      n_irq_q <= ~|(irq_stat & ~irq_mask);
    end
  end

  assign n_fiq_o = n_fiq_q;
  assign n_irq_o = n_irq_q;
endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int unsigned N_SRC = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             n_fiq_i,
  input logic             n_irq_i,
  input logic [N_SRC-1:0] stat_i,
  input logic [N_SRC-1:0] route_i,
  input logic [N_SRC-1:0] fmask_i,
  input logic [N_SRC-1:0] imask_i,
  input logic [N_SRC-1:0] smask_i,
  input logic [N_SRC-1:0] trig_i,
  input logic [N_SRC-1:0] clr_i
);
  AST_FIQ_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_fiq_i == !$past(|(stat_i & route_i & ~fmask_i)));  // R8
  AST_IRQ_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_irq_i == !$past(|(stat_i & ~route_i & ~imask_i)));  // R8

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_i[g] && trig_i[g] && !clr_i[g]) |=> stat_i[g]);  // R4
    AST_MASK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_i[g] && smask_i[g]) |=> !stat_i[g]);  // R2
  end
endmodule

bind dic_top dic_checker #(.N_SRC(N_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .n_fiq_i(n_fiq_o),
  .n_irq_i(n_irq_o),
  .stat_i (stat),
  .route_i(route),
  .fmask_i(fiq_mask),
  .imask_i(irq_mask),
  .smask_i(src_mask),
  .trig_i (trig),
  .clr_i  (clr)
);

// File: tb/dic_top_tb.sv
module dic_top_tb;
  localparam logic [26:0] ALL = 27'h3FFFFFF;
  localparam logic [26:0] EN  = 27'h4000000;
  localparam logic [3:0] A_SMASK = 0, A_TRIG = 1, A_POL = 2, A_ROUTE = 3, A_FMASK = 4,
                         A_IMASK = 5, A_CLR = 6, A_TEST = 7, A_FST = 8, A_IST = 9, A_SWI = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [26:0] wdata = '0;
  logic [26:0] rdata;
  logic        n_fiq, n_irq;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  dic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .n_fiq_o(n_fiq), .n_irq_o(n_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [26:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [26:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src = '0;
    idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [26:0] v, f, i2;
    idle(2); rst_n = 1'b1; idle(1);

    // R1 reset state
    chk("R1 n_fiq", n_fiq, 1); chk("R1 n_irq", n_irq, 1);
    rd(A_SMASK, v); chk("R1 smask", v, ALL);
    rd(A_TRIG, v);  chk("R1 trig", v, 0);
    rd(A_POL, v);   chk("R1 pol", v, 27'h2000000);
    rd(A_ROUTE, v); chk("R1 route", v, 0);
    rd(A_FMASK, v); chk("R1 fmask", v, ALL);
    rd(A_IMASK, v); chk("R1 imask", v, ALL);
    rd(A_TEST, v);  chk("R1 test", v, 0);
    rd(A_FST, v);   chk("R1 fstat", v, 0);
    rd(A_IST, v);   chk("R1 istat", v, 0);
    rd(A_SWI, v);   chk("R1 swi", v, 0);

    // R2 masked level source gives no status
    wr(A_POL, 27'h8); wr(A_TEST, EN | 27'h8); idle(3);
    rd(A_IST, v); chk("R2 masked", v, 0);
    wr(A_SMASK, ALL & ~27'h8); idle(3);
    rd(A_IST, v); chk("R2 unmasked", v, 27'h8);

    // R8 group mask holds off request while status is visible
    wr(A_SMASK, ALL & ~27'h10); wr(A_ROUTE, 27'h10); wr(A_POL, 27'h10);
    wr(A_TEST, EN | 27'h10); idle(3);
    rd(A_FST, v); chk("R8 fstat", v, 27'h10);
    chk("R8 n_fiq masked", n_fiq, 1);
    wr(A_FMASK, ALL & ~27'h10); idle(3);
    chk("R8 n_fiq unmasked", n_fiq, 0);
    chk("R8 n_irq", n_irq, 1);

    // sweep R3 R4 R5 R7 over sources and modes via test mode
    wr(A_FMASK, 0); wr(A_IMASK, 0);
    for (int s = 0; s < 25; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          logic [26:0] bi, idv, acv, ef, ei;
          logic        rt;
          string       tg;
          bi  = 27'(1) << s;
          rt  = s[0];
          idv = p ? 27'h0 : bi;
          acv = p ? bi : 27'h0;
          ef  = rt ? bi : 27'h0;
          ei  = rt ? 27'h0 : bi;
          tg  = m ? "R4" : "R3";
          wr(A_SMASK, ALL & ~bi); wr(A_TRIG, m ? bi : 27'h0);
          wr(A_POL, p ? bi : 27'h0); wr(A_ROUTE, rt ? bi : 27'h0);
          wr(A_TEST, EN | idv); idle(2); wr(A_CLR, ALL); idle(3);
          rd(A_FST, f); rd(A_IST, i2);
          chk({tg, " idle"}, {f, i2[4:0]}, 0);
          wr(A_TEST, EN | acv); idle(3);
          rd(A_FST, f); rd(A_IST, i2);
          chk({tg, " R7 fstat"}, f, ef); chk({tg, " R7 istat"}, i2, ei);
          chk("R8 n_fiq sweep", n_fiq, !rt); chk("R8 n_irq sweep", n_irq, rt);
          if (m) begin
            wr(A_TEST, EN | idv); idle(3);
            rd(rt ? A_FST : A_IST, v); chk("R4 hold", v, bi);
            wr(A_CLR, bi); idle(3);
            rd(rt ? A_FST : A_IST, v); chk("R5 edge clear", v, 0);
          end else begin
            wr(A_CLR, bi); idle(3);
            rd(rt ? A_FST : A_IST, v); chk("R5 level ignore", v, bi);
            wr(A_TEST, EN | idv); idle(3);
            rd(rt ? A_FST : A_IST, v); chk("R3 release", v, 0);
          end
        end
      end
    end

    // R11 external path latency, R9 test override
    do_reset();
    wr(A_SMASK, ALL & ~27'h80); wr(A_POL, 27'h80); wr(A_IMASK, 0);
    @(negedge clk); src = 25'h80;
    @(negedge clk);
    @(negedge clk); rd(A_IST, v); chk("R11 after 2 edges", v, 0);
    @(negedge clk); rd(A_IST, v); chk("R11 after 3 edges", v, 27'h80);
    chk("R11 n_irq not yet", n_irq, 1);
    @(negedge clk); chk("R11 n_irq", n_irq, 0);
    wr(A_TEST, EN); idle(3);
    rd(A_IST, v); chk("R9 src ignored", v, 0);
    wr(A_TEST, EN | 27'h80); idle(3);
    rd(A_IST, v); chk("R9 test drives", v, 27'h80);
    do_reset();
    rd(A_TEST, v); chk("R9 reset clears enable", v, 0);

    // R6 set and clear collide
    wr(A_SMASK, ALL & ~27'h20); wr(A_TRIG, 27'h20); wr(A_POL, 27'h20);
    @(negedge clk); src = 25'h20;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = A_CLR; wdata = 27'h20;
    @(negedge clk); we = 1'b0;
    idle(1); rd(A_IST, v); chk("R6 set wins", v, 27'h20);
    wr(A_CLR, 27'h20); idle(2);
    rd(A_IST, v); chk("R5 clear after", v, 0);

    // R10 software source
    do_reset();
    wr(A_SMASK, ALL & ~27'h2000000); wr(A_TRIG, ALL); wr(A_POL, 0);
    rd(A_TRIG, v); chk("R10 trig fixed", v[25], 0);
    rd(A_POL, v);  chk("R10 pol fixed", v[25], 1);
    idle(3); rd(A_IST, v); chk("R10 idle", v, 0);
    wr(A_SWI, 1); idle(3);
    rd(A_IST, v); chk("R10 active", v, 27'h2000000);
    wr(A_CLR, 27'h2000000); idle(3);
    rd(A_IST, v); chk("R10 clear ignored", v, 27'h2000000);
    wr(A_SWI, 0); idle(3);
    rd(A_IST, v); chk("R10 release", v, 0);

    finish_run();
  end
endmodule